// File: doc/BRIEF.md
# Layered LDPC Two-State Check-Node Processor

This block performs the update of one parity-check row inside a horizontally layered LDPC decoder. It treats the row as a two-state trellis, with one state for even parity and one for odd parity. For every variable node attached to the row, it receives that node's current soft output and the check-to-variable message that this row sent to it in the previous iteration. The block returns a fresh check-to-variable message and the refreshed soft output for that node, so the next layer sees up-to-date soft outputs at once.

Edges arrive serially after a start pulse that carries the row degree. They are held in an internal row buffer. A forward recursion runs while the edges are loaded. A backward recursion then runs from the last edge toward the first and produces the extrinsic messages. Finally the results are streamed out in the order the edges came in. All recursion arithmetic uses max-star, which is a max followed by a small correction that depends on the operand distance. All saturation is symmetric about zero.

Top module: `ldpc_layer_cnu`

## Requirements
- R1: For each edge, the variable-to-check value is the input soft output minus the old check-to-variable message. The old message is first scaled up by 2^LSB_SHIFT so that the two LSB weights line up.
- R2: The forward metric is set to the even-parity value before the first edge. The even-parity value is the largest positive metric, 2^(MET_W-1)-1, which is 63 by default. At each edge the metric becomes step(a,m) = maxstar(a,m) - maxstar(a+m,0), where m is the variable-to-check value saturated to MET_W bits.
- R3: The backward metric is set to the even-parity value after the last edge. It steps with the same function from the last edge toward the first. Every metric is saturated symmetrically to ±(2^(MET_W-1)-1).
- R4: The new message for edge k is step(alpha_k, beta_k+1), where alpha_k is the forward metric before edge k and beta_k+1 is the backward metric after edge k. This value is arithmetically shifted right by LSB_SHIFT and then saturated to ±(2^(MSG_W-1)-1), which is ±31 by default.
- R5: maxstar(a,b) is max(a,b)+1 when |a-b| ≤ 2, and max(a,b) otherwise.
- R6: The variable-to-check value is saturated separately to VS_W bits for the soft-output path. The new soft output is that value plus the new message scaled by 2^LSB_SHIFT, saturated to ±(2^(SO_W-1)-1), which is ±127 by default.
- R7: The row degree is latched from `degree` together with `start` while the block is idle. The valid range is 2 to MAX_DEG (20). After all `degree` edges have been loaded and the backward pass is done, `outValid` stays high for exactly `degree` consecutive cycles and emits results in input order. `busy` then returns low.
- R8: While the block is busy, `start` is ignored. Outside the loading phase, `inValid` is ignored. Neither changes the results of the row in progress.
- R9: Reset, including a reset in the middle of a row, leaves `busy` and `outValid` low.
- R10: For a degree-2 row, the new message of each edge equals the other edge's variable-to-check value, so the two new soft outputs are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a row when idle |
| degree | input | $clog2(MAX_DEG+1) | Number of edges in the row, taken with start |
| inValid | input | 1 | One edge is presented this cycle |
| inSo | input | SO_W | Current soft output of the edge's variable (signed) |
| inCtov | input | MSG_W | Previous check-to-variable message for the edge (signed) |
| busy | output | 1 | A row is being loaded, processed or emitted |
| outValid | output | 1 | An edge result is presented this cycle |
| outSo | output | SO_W | Updated soft output (signed) |
| outCtov | output | MSG_W | New check-to-variable message (signed) |

## Verification
The bench targets the places where a two-state trellis update goes wrong in ways that are hard to see.

- **Degree-2 rows.** A wrong recursion seed or a backward pass off by one edge makes each message echo its own input instead of the partner's value.
- **Near-equal operands.** A dropped max-star correction shifts the message by one LSB.
- **Saturation.** Rails pushed to ±127 and ±31 expose a missing or asymmetric clamp, which shows up as wrap-around or as the most negative code.
- **Protocol.** Stray `start` and `inValid` pulses during the backward pass, and a reset in the middle of a row, would corrupt the buffered row or leave the block stuck busy if the controller honoured them.

// File: rtl/ldpc_cnu_pkg.sv
`timescale 1ns/1ps
package ldpc_cnu_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic init;   // seed forward metric
    logic load;   // capture one edge
    logic bInit;  // seed backward metric
    logic back;   // one backward step
    logic emit;   // present one result
  } cnuStrobe_t;

  // Distances up to this value earn a one-LSB max-star correction
  localparam int CORR_SPAN = 2;

  function automatic int satSym(int v, int w);
    int lim;
    lim = (1 <<< (w - 1)) - 1;
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic int maxStar(int a, int b);
    int d;
    int m;
    d = (a > b) ? a - b : b - a;
    m = (a > b) ? a : b;
    return m + ((d <= CORR_SPAN) ? 1 : 0);
  endfunction

  // Two-state trellis step, shared by both recursions and the extrinsic
  function automatic int trellisStep(int a, int m);
    return maxStar(a, m) - maxStar(a + m, 0);
  endfunction

endpackage

// File: rtl/ldpc_cnu_ctrl.sv
`timescale 1ns/1ps
module ldpc_cnu_ctrl
  import ldpc_cnu_pkg::*;
#(
  parameter int MAX_DEG = 20,
  parameter int DEG_W   = $clog2(MAX_DEG + 1),
  parameter int IDX_W   = $clog2(MAX_DEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEG_W-1:0] degree,
  input  logic             inValid,
  output cnuStrobe_t       strb,
  output logic [IDX_W-1:0] idx,
  output logic             busy
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_BACK, S_EMIT} cnuState_t;

  cnuState_t        state;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] lastR;
  logic [IDX_W-1:0] lastIn;

  // Clamp the requested degree into 2..MAX_DEG, stored as last index
  always_comb begin
    if (degree < DEG_W'(2))
      lastIn = IDX_W'(1);
    else if (degree > DEG_W'(MAX_DEG))
      lastIn = IDX_W'(MAX_DEG - 1);
    else
      lastIn = IDX_W'(degree - DEG_W'(1));
  end

  always_comb begin
    strb.init  = (state == S_IDLE) && start;
    strb.load  = (state == S_LOAD) && inValid;
    strb.bInit = strb.load && (cnt == lastR);
    strb.back  = (state == S_BACK);
    strb.emit  = (state == S_EMIT);
  end

  assign idx  = cnt;
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      lastR <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          lastR <= lastIn;
          cnt   <= '0;
          state <= S_LOAD;
        end
        S_LOAD: if (inValid) begin
          if (cnt == lastR) state <= S_BACK;
          else cnt <= cnt + IDX_W'(1);
        end
        S_BACK: begin
          if (cnt == '0) state <= S_EMIT;
          else cnt <= cnt - IDX_W'(1);
        end
        default: begin
          if (cnt == lastR) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + IDX_W'(1);
          end
        end
      endcase
    end
  end

  // R8: a start pulse during a row must not disturb the latched degree
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(lastR));

endmodule

// File: rtl/ldpc_cnu_dp.sv
`timescale 1ns/1ps
module ldpc_cnu_dp
  import ldpc_cnu_pkg::*;
#(
  parameter int SO_W      = 8,
  parameter int MSG_W     = 6,
  parameter int MET_W     = 7,
  parameter int VS_W      = 9,
  parameter int LSB_SHIFT = 0,
  parameter int MAX_DEG   = 20,
  parameter int IDX_W     = $clog2(MAX_DEG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  cnuStrobe_t              strb,
  input  logic [IDX_W-1:0]        idx,
  input  logic signed [SO_W-1:0]  inSo,
  input  logic signed [MSG_W-1:0] inCtov,
  output logic                    outValid,
  output logic signed [SO_W-1:0]  outSo,
  output logic signed [MSG_W-1:0] outCtov
);

  localparam int MET_MAX = (1 <<< (MET_W - 1)) - 1;  // even-parity seed

  logic signed [MET_W-1:0] alphaR, betaR;
  logic signed [MET_W-1:0] alphaB [MAX_DEG];
  logic signed [MET_W-1:0] muRecB [MAX_DEG];
  logic signed [VS_W-1:0]  muSoB  [MAX_DEG];
  logic signed [MSG_W-1:0] extB   [MAX_DEG];

  int vtocI, muRecI, extI, soI;

  always_comb begin
    vtocI  = int'(inSo) - (int'(inCtov) <<< LSB_SHIFT);
    muRecI = satSym(vtocI, MET_W);
    extI   = trellisStep(int'(alphaB[idx]), int'(betaR));
    soI    = satSym(int'(muSoB[idx]) + (int'(extB[idx]) <<< LSB_SHIFT), SO_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alphaR <= MET_W'(MET_MAX);
      betaR  <= MET_W'(MET_MAX);
    end else begin
      if (strb.init) alphaR <= MET_W'(MET_MAX);
      else if (strb.load)
        alphaR <= MET_W'(satSym(trellisStep(int'(alphaR), muRecI), MET_W));
      if (strb.bInit) betaR <= MET_W'(MET_MAX);
      else if (strb.back)
        betaR <= MET_W'(satSym(trellisStep(int'(betaR), int'(muRecB[idx])), MET_W));
    end
  end

  always_ff @(posedge clk) begin
    if (strb.load) begin
      alphaB[idx] <= alphaR;
      muRecB[idx] <= MET_W'(muRecI);
      muSoB[idx]  <= VS_W'(satSym(vtocI, VS_W));
    end
    if (strb.back)
      extB[idx] <= MSG_W'(satSym(extI >>> LSB_SHIFT, MSG_W));
  end

  assign outValid = strb.emit;
  assign outSo    = strb.emit ? SO_W'(soI) : '0;
  assign outCtov  = strb.emit ? extB[idx] : '0;

  // R2 / R3: recursion metrics never reach the unused most-negative code
  a_r2_alpha_sym: assert property (@(posedge clk) disable iff (!rst_n)
    alphaR != {1'b1, {(MET_W-1){1'b0}}});
  a_r3_beta_sym: assert property (@(posedge clk) disable iff (!rst_n)
    betaR != {1'b1, {(MET_W-1){1'b0}}});
  // R4 / R6: emitted values respect symmetric saturation
  a_r4_ctov_sym: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outCtov != {1'b1, {(MSG_W-1){1'b0}}});
  a_r6_so_sym: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outSo != {1'b1, {(SO_W-1){1'b0}}});

endmodule

// File: rtl/ldpc_layer_cnu.sv
`timescale 1ns/1ps
module ldpc_layer_cnu
  import ldpc_cnu_pkg::*;
#(
  parameter int SO_W      = 8,
  parameter int MSG_W     = 6,
  parameter int MET_W     = 7,
  parameter int VS_W      = 9,
  parameter int LSB_SHIFT = 0,
  parameter int MAX_DEG   = 20,
  localparam int DEG_W    = $clog2(MAX_DEG + 1),
  localparam int IDX_W    = $clog2(MAX_DEG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DEG_W-1:0]        degree,
  input  logic                    inValid,
  input  logic signed [SO_W-1:0]  inSo,
  input  logic signed [MSG_W-1:0] inCtov,
  output logic                    busy,
  output logic                    outValid,
  output logic signed [SO_W-1:0]  outSo,
  output logic signed [MSG_W-1:0] outCtov
);

  cnuStrobe_t       strb;
  logic [IDX_W-1:0] idx;

  ldpc_cnu_ctrl #(.MAX_DEG(MAX_DEG), .DEG_W(DEG_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .degree(degree),
    .inValid(inValid), .strb(strb), .idx(idx), .busy(busy));

  ldpc_cnu_dp #(.SO_W(SO_W), .MSG_W(MSG_W), .MET_W(MET_W), .VS_W(VS_W),
                .LSB_SHIFT(LSB_SHIFT), .MAX_DEG(MAX_DEG), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .idx(idx), .inSo(inSo),
    .inCtov(inCtov), .outValid(outValid), .outSo(outSo), .outCtov(outCtov));

  // R7: results leave as one unbroken burst that ends the row
  a_r7_burst: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |=> (outValid || !busy));
  // R9: nothing is emitted while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !outValid);

endmodule

// File: tb/ldpc_layer_cnu_test.sv
`timescale 1ns/1ps
module ldpc_layer_cnu_test;
  import ldpc_cnu_pkg::*;

  localparam int SO_W = 8, MSG_W = 6, MET_W = 7, VS_W = 9, SH = 0, MAXD = 20;
  localparam int MET_MAX = (1 <<< (MET_W - 1)) - 1;

  logic clk = 0, rst_n = 0, start = 0, inValid = 0;
  logic [4:0] degree = '0;
  logic signed [SO_W-1:0] inSo = '0;
  logic signed [MSG_W-1:0] inCtov = '0;
  logic busy, outValid;
  logic signed [SO_W-1:0] outSo;
  logic signed [MSG_W-1:0] outCtov;

  ldpc_layer_cnu uut (.clk(clk), .rst_n(rst_n), .start(start), .degree(degree),
    .inValid(inValid), .inSo(inSo), .inCtov(inCtov), .busy(busy),
    .outValid(outValid), .outSo(outSo), .outCtov(outCtov));

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  int soIn [MAXD];
  int ctIn [MAXD];
  int expSo [MAXD];
  int expCt [MAXD];
  int gotSo [MAXD];
  int gotCt [MAXD];

  // rows: degree, so base, so step, ctov base, ctov step
  localparam int VEC [8][5] = '{
    '{2,  20, -27,   3,  -5},
    '{3,  50,  33,  -7,  11},
    '{5, -90,  41,  12,  -9},
    '{8,  15,  -8,   1,   4},
    '{20, -5,  37,  -3,  13},
    '{4, 120,   3, -30,  -1},
    '{7,-100, -19,  25,   6},
    '{12, 64, -50,   0,  17}};

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fold(int v, int lim);
    int r;
    r = v % (2 * lim + 1);
    if (r < 0) r += 2 * lim + 1;
    return r - lim;
  endfunction

  // Reference model written from the requirements
  function automatic void model(int deg);
    int muR [MAXD];
    int muS [MAXD];
    int al [MAXD+1];
    int be [MAXD+1];
    for (int k = 0; k < deg; k++) begin
      muR[k] = satSym(soIn[k] - (ctIn[k] <<< SH), MET_W);        // R1
      muS[k] = satSym(soIn[k] - (ctIn[k] <<< SH), VS_W);
    end
    al[0] = MET_MAX;                                               // R2
    for (int k = 0; k < deg; k++) al[k+1] = satSym(trellisStep(al[k], muR[k]), MET_W);
    be[deg] = MET_MAX;                                             // R3
    for (int k = deg - 1; k >= 0; k--) be[k] = satSym(trellisStep(be[k+1], muR[k]), MET_W);
    for (int k = 0; k < deg; k++) begin
      expCt[k] = satSym(trellisStep(al[k], be[k+1]) >>> SH, MSG_W); // R4
      expSo[k] = satSym(muS[k] + (expCt[k] <<< SH), SO_W);         // R6
    end
  endfunction

  task automatic runRow(int deg, bit disturb);
    int w;
    model(deg);
    @(negedge clk); start = 1; degree = 5'(deg);
    for (int k = 0; k < deg; k++) begin
      @(negedge clk); start = 0; inValid = 1;
      inSo = SO_W'(soIn[k]); inCtov = MSG_W'(ctIn[k]);
    end
    @(negedge clk); inValid = 0;
    if (disturb) begin  // R8: stray start / edge during backward pass
      start = 1; degree = 5'd3; inValid = 1; inSo = 8'sd99; inCtov = -6'sd20;
      @(negedge clk);
      @(negedge clk); start = 0; inValid = 0;
    end
    w = 0;
    while (!outValid && w < 100) begin @(negedge clk); w++; end
    check(outValid, "R7 output burst start", int'(outValid), 1);
    for (int k = 0; k < deg; k++) begin
      check(outValid, "R7 burst contiguous", int'(outValid), 1);
      gotSo[k] = int'(outSo); gotCt[k] = int'(outCtov);
      check(gotCt[k] == expCt[k], "R4 new ctov", gotCt[k], expCt[k]);
      check(gotSo[k] == expSo[k], "R6 new soft output", gotSo[k], expSo[k]);
      @(negedge clk);
    end
    check(!busy, "R7 idle after burst", int'(busy), 0);
    check(!outValid, "R7 burst length", int'(outValid), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy, "R9 busy after reset", int'(busy), 0);
    check(!outValid, "R9 outValid after reset", int'(outValid), 0);
    rst_n = 1;
    @(negedge clk);

    // table-driven rows
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < VEC[r][0]; k++) begin
        soIn[k] = fold(VEC[r][1] + k * VEC[r][2], 127);
        ctIn[k] = fold(VEC[r][3] + k * VEC[r][4], 31);
      end
      runRow(VEC[r][0], 1'b0);
    end

    // R10 / R1: degree 2 hand values
    soIn[0] = 20; soIn[1] = -7; ctIn[0] = 3; ctIn[1] = -2;
    runRow(2, 1'b0);
    check(gotCt[0] == -5, "R10 ctov0 is partner vtoc", gotCt[0], -5);
    check(gotCt[1] == 17, "R10 ctov1 is partner vtoc", gotCt[1], 17);
    check(gotSo[0] == 12 && gotSo[1] == 12, "R1 soft outputs equal", gotSo[1], 12);

    // R5: near-equal operands take the correction
    soIn[0] = 10; soIn[1] = 4; soIn[2] = 10; ctIn[0] = 0; ctIn[1] = 0; ctIn[2] = 0;
    runRow(3, 1'b0);
    check(gotCt[1] == -9, "R5 maxstar correction", gotCt[1], -9);
    check(gotSo[1] == -5, "R5 soft output", gotSo[1], -5);

    // R6: saturation rails
    soIn[0] = 127; soIn[1] = 127; ctIn[0] = -31; ctIn[1] = -31;
    runRow(2, 1'b0);
    check(gotCt[0] == 31, "R4 ctov clamp", gotCt[0], 31);
    check(gotSo[0] == 127, "R6 soft output clamp", gotSo[0], 127);

    // R8: stray start and inValid while busy
    for (int k = 0; k < 6; k++) begin
      soIn[k] = fold(7 + 29 * k, 127); ctIn[k] = fold(-4 + 9 * k, 31);
    end
    runRow(6, 1'b1);

    // R9: reset in the middle of a row
    @(negedge clk); start = 1; degree = 5'd5;
    @(negedge clk); start = 0; inValid = 1; inSo = 8'sd3; inCtov = 6'sd1;
    @(negedge clk); inValid = 0; rst_n = 0;
    @(negedge clk);
    check(!busy, "R9 busy after mid-row reset", int'(busy), 0);
    check(!outValid, "R9 outValid after mid-row reset", int'(outValid), 0);
    rst_n = 1;
    @(negedge clk);
    soIn[0] = 20; soIn[1] = -7; ctIn[0] = 3; ctIn[1] = -2;
    runRow(2, 1'b0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule